// File: doc/BRIEF.md
# Interprocessor Interrupt Command Issuer

This block is the sending side of a per-processor local interrupt controller. Software programs a 64-bit command register through a 32-bit register port, one half at a time. The upper half holds only the target address. A write to the lower half sets every other field of the command and starts the send. The block then builds one 64-bit interrupt message and offers it on a valid/ready output port. A message that targets the issuing processor appears on a separate loopback port instead, or on both ports for a broadcast that includes the issuer.

Shorthand codes in the command replace the programmed destination where needed. Both broadcast codes force the all-ones destination, and the "everyone but me" code also forces physical addressing. A status bit shows when a send is still in flight. A second command written during that time is dropped, and a sticky error bit records that it was dropped. The reserved delivery type does not start a send.

Top module: `ipi_cmd_issuer`

## Requirements
- R1: After reset, both register halves read as zero, `msgValid` and `loopValid` are low, and the status bit (low-half bit 12) reads 0.
- R2: A write with `regSel`=1 stores `regWrData[31:24]` as the destination. It changes no other field and starts no send. The high half reads back as {destination, 24'h0}.
- R3: Low-half layout on write and read: vector [7:0], delivery type [10:8], destination mode [11], status [12] (read-only), level [14], trigger [15], shorthand [19:18], sticky error [31] (read-only). When no send is pending, a low write with a non-reserved type stores these fields and starts a send. The message is {dest[63:56], 36'h0, shorthand[19:18], 2'b0, trigger[15], level[14], 2'b0, destination mode[11], type[10:8], vector[7:0]}. It becomes visible in the cycle after the write.
- R4: Shorthand 00 emits the stored destination and the written destination mode, on the external port only.
- R5: Shorthand 01 (self) raises `loopValid` for exactly one cycle with the message and does not raise `msgValid`. The status bit clears one cycle later.
- R6: Shorthand 10 (all including self) emits destination FFh on the external port and also pulses the loopback port once.
- R7: Shorthand 11 (all excluding self) emits destination FFh with destination mode forced to 0 (physical), on the external port only.
- R8: The status bit reads 1 from the cycle after the triggering write. It returns to 0 in the cycle after `msgValid && msgReady`.
- R9: While `msgValid` is high and `msgReady` is low, `msgValid` stays high and `msgData` does not change.
- R10: A low write while a send is pending changes no field and starts nothing. It sets the error bit [31], which stays set until reset.
- R11: A low write with the reserved type 011 stores the fields but starts no send, and the status bit stays 0.
- R12: For type 100 (NMI), the emitted vector is 00h. For every other type, the written vector is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Half select for read and write: 0 low, 1 high |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected half |
| msgValid | output | 1 | External message valid |
| msgReady | input | 1 | External message accepted |
| msgData | output | 64 | External message |
| loopValid | output | 1 | One-cycle loopback message strobe |
| loopData | output | 64 | Loopback message |

## Verification
The send path is driven with each of the four shorthand codes. Two separate destinations and destination-mode values are used, so a forced FFh or a forced physical mode can be told apart from a passed-through field. Sends are run with `msgReady` held low for several cycles and with it high at once. This separates the status bit's timing and the hold rule from a one-cycle handshake. Writes that collide with a pending send, a reserved type, and an NMI carrying a non-zero vector show whether fields leak into stored state or into the message. A reference model steps in parallel with the design and is compared every cycle.

// File: rtl/ipi_issuer_pkg.sv
package ipi_issuer_pkg;
  localparam int REG_W    = 32;
  localparam int MSG_W    = 64;
  localparam int DEST_W   = 8;
  localparam int VEC_W    = 8;
  localparam int TYPE_W   = 3;
  localparam int SH_W     = 2;
  localparam int TYPE_LSB = 8;
  localparam int DM_BIT   = 11;
  localparam int STAT_BIT = 12;
  localparam int LVL_BIT  = 14;
  localparam int TRIG_BIT = 15;
  localparam int SH_LSB   = 18;
  localparam int ERR_BIT  = 31;
  localparam int DEST_LSB = REG_W - DEST_W;
  localparam logic SEL_LOW  = 1'b0;
  localparam logic SEL_HIGH = 1'b1;

  typedef enum logic [SH_W-1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef enum logic [TYPE_W-1:0] {
    T_FIXED  = 3'b000,
    T_LOWPRI = 3'b001,
    T_SMI    = 3'b010,
    T_RSVD   = 3'b011,
    T_NMI    = 3'b100,
    T_INIT   = 3'b101,
    T_START  = 3'b110,
    T_SPARE  = 3'b111
  } msg_type_e;

  typedef struct packed {
    shorthand_e             sh;
    logic                   trig;
    logic                   lvl;
    logic                   dm;
    msg_type_e              mtype;
    logic [VEC_W-1:0]       vec;
  } low_fields_t;

  typedef struct packed {
    logic loadDest;
    logic loadLow;
    logic launch;
  } ctrl_strobes_t;
endpackage

// File: rtl/ipi_issuer_ctrl.sv
module ipi_issuer_ctrl
  import ipi_issuer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic             msgReady,
  output ctrl_strobes_t    strobes,
  output logic             msgValid,
  output logic             loopValid,
  output logic             pending,
  output logic             errFlag
);
  logic       lowWr;
  shorthand_e wrSh;
  msg_type_e  wrType;
  logic       toExt;
  logic       toLoop;

  assign wrSh    = shorthand_e'(regWrData[SH_LSB +: SH_W]);
  assign wrType  = msg_type_e'(regWrData[TYPE_LSB +: TYPE_W]);
  assign lowWr   = regWrEn && (regSel == SEL_LOW);
  assign pending = msgValid | loopValid;
  assign toExt   = (wrSh != SH_SELF);
  assign toLoop  = (wrSh == SH_SELF) || (wrSh == SH_ALL);

  always_comb begin
    strobes          = '0;
    strobes.loadDest = regWrEn && (regSel == SEL_HIGH);
    strobes.loadLow  = lowWr && !pending;
    strobes.launch   = lowWr && !pending && (wrType != T_RSVD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid  <= 1'b0;
      loopValid <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      loopValid <= strobes.launch && toLoop;
      if (strobes.launch && toExt) msgValid <= 1'b1;
      else if (msgValid && msgReady) msgValid <= 1'b0;
      if (lowWr && pending) errFlag <= 1'b1;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  assert_loop_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    loopValid |=> !loopValid);
  assert_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(regWrEn && regSel == SEL_LOW));
endmodule

// File: rtl/ipi_issuer_datapath.sv
module ipi_issuer_datapath
  import ipi_issuer_pkg::*;
#(
  parameter logic [DEST_W-1:0] BCAST_DEST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobes_t    strobes,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regSel,
  input  logic             pending,
  input  logic             errFlag,
  input  logic             msgValid,
  input  logic             msgReady,
  output logic [REG_W-1:0] regRdData,
  output logic [MSG_W-1:0] msgData
);
  localparam int GAP_W = MSG_W - DEST_W - SH_LSB - SH_W;

  logic [DEST_W-1:0] destQ;
  low_fields_t       lowQ;
  low_fields_t       wrFields;
  logic [MSG_W-1:0]  msgQ;
  logic [DEST_W-1:0] effDest;
  logic              effDm;
  logic [VEC_W-1:0]  effVec;

  always_comb begin
    wrFields.sh    = shorthand_e'(regWrData[SH_LSB +: SH_W]);
    wrFields.trig  = regWrData[TRIG_BIT];
    wrFields.lvl   = regWrData[LVL_BIT];
    wrFields.dm    = regWrData[DM_BIT];
    wrFields.mtype = msg_type_e'(regWrData[TYPE_LSB +: TYPE_W]);
    wrFields.vec   = regWrData[VEC_W-1:0];
  end

  always_comb begin
    effDest = destQ;
    effDm   = wrFields.dm;
    effVec  = wrFields.vec;
    if (wrFields.sh == SH_ALL || wrFields.sh == SH_OTHERS) effDest = BCAST_DEST;
    if (wrFields.sh == SH_OTHERS) effDm = 1'b0;
    if (wrFields.mtype == T_NMI) effVec = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destQ <= '0;
      lowQ  <= '0;
      msgQ  <= '0;
    end else begin
      if (strobes.loadDest) destQ <= regWrData[DEST_LSB +: DEST_W];
      if (strobes.loadLow)  lowQ  <= wrFields;
      if (strobes.launch)
        msgQ <= {effDest, {GAP_W{1'b0}}, wrFields.sh, 2'b00, wrFields.trig,
                 wrFields.lvl, 2'b00, effDm, wrFields.mtype, effVec};
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel == SEL_HIGH) begin
      regRdData[DEST_LSB +: DEST_W] = destQ;
    end else begin
      regRdData[ERR_BIT]               = errFlag;
      regRdData[SH_LSB +: SH_W]        = lowQ.sh;
      regRdData[TRIG_BIT]              = lowQ.trig;
      regRdData[LVL_BIT]               = lowQ.lvl;
      regRdData[STAT_BIT]              = pending;
      regRdData[DM_BIT]                = lowQ.dm;
      regRdData[TYPE_LSB +: TYPE_W]    = lowQ.mtype;
      regRdData[VEC_W-1:0]             = lowQ.vec;
    end
  end

  assign msgData = msgQ;

  assert_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> $stable(msgData));
  assert_bcast_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgData[SH_LSB+1] |-> msgData[MSG_W-1 -: DEST_W] == BCAST_DEST);
  assert_others_phys_R7: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgData[SH_LSB +: SH_W] == SH_OTHERS |-> !msgData[DM_BIT]);
  assert_nmi_vec_R12: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgData[TYPE_LSB +: TYPE_W] == T_NMI |-> msgData[VEC_W-1:0] == '0);
endmodule

// File: rtl/ipi_cmd_issuer.sv
module ipi_cmd_issuer
  import ipi_issuer_pkg::*;
#(
  parameter logic [DEST_W-1:0] BCAST_DEST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             msgValid,
  input  logic             msgReady,
  output logic [MSG_W-1:0] msgData,
  output logic             loopValid,
  output logic [MSG_W-1:0] loopData
);
  ctrl_strobes_t strobes;
  logic          pending;
  logic          errFlag;

  ipi_issuer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .msgReady(msgReady), .strobes(strobes),
    .msgValid(msgValid), .loopValid(loopValid), .pending(pending),
    .errFlag(errFlag)
  );

  ipi_issuer_datapath #(.BCAST_DEST(BCAST_DEST)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .regSel(regSel), .pending(pending), .errFlag(errFlag),
    .msgValid(msgValid), .msgReady(msgReady), .regRdData(regRdData),
    .msgData(msgData)
  );

  assign loopData = msgData;

  assert_idle_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady && !loopValid |=> !regRdData[STAT_BIT] || regSel);
endmodule

// File: tb/ipi_cmd_issuer_bench.sv
`timescale 1ns/1ps
module ipi_cmd_issuer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [63:0] msgData;
  logic        loopValid;
  logic [63:0] loopData;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // reference model state
  logic [7:0]  mDest = '0;
  logic [31:0] mLow = '0;
  logic        mErr = 1'b0;
  logic        mExt = 1'b0;
  logic        mLoop = 1'b0;
  logic [63:0] mMsg = '0;

  always #2 clk = ~clk;

  ipi_cmd_issuer u_ipi_cmd_issuer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .msgValid(msgValid),
    .msgReady(msgReady), .msgData(msgData), .loopValid(loopValid),
    .loopData(loopData)
  );

  function automatic logic [31:0] lowWord(logic [1:0] sh, logic trig, logic lvl,
                                          logic dm, logic [2:0] ty, logic [7:0] vec);
    return {12'h0, sh, 2'b00, trig, lvl, 2'b00, dm, ty, vec};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference, stepped on every edge and compared 1 ns later
  always @(posedge clk) begin
    logic pend, nextLoop;
    logic [1:0] sh;
    logic [2:0] ty;
    logic [7:0] d, v;
    logic dm;
    logic [31:0] expRd;
    if (!rstN) begin
      mDest = '0; mLow = '0; mErr = 0; mExt = 0; mLoop = 0; mMsg = '0;
    end else begin
      pend = mExt || mLoop;
      nextLoop = 1'b0;
      if (mExt && msgReady) mExt = 1'b0;
      if (regWrEn && regSel) mDest = regWrData[31:24];
      if (regWrEn && !regSel) begin
        if (pend) mErr = 1'b1;
        else begin
          mLow = regWrData & 32'h000C_CFFF;
          sh = regWrData[19:18];
          ty = regWrData[10:8];
          if (ty != 3'b011) begin
            d  = (sh[1]) ? 8'hFF : mDest;
            dm = (sh == 2'b11) ? 1'b0 : regWrData[11];
            v  = (ty == 3'b100) ? 8'h00 : regWrData[7:0];
            mMsg = {d, 36'h0, sh, 2'b00, regWrData[15], regWrData[14], 2'b00, dm, ty, v};
            if (sh != 2'b01) mExt = 1'b1;
            if (sh == 2'b01 || sh == 2'b10) nextLoop = 1'b1;
          end
        end
      end
      mLoop = nextLoop;
    end
    #1;
    check(curReq, "msgValid", 64'(msgValid), 64'(mExt));
    check(curReq, "loopValid", 64'(loopValid), 64'(mLoop));
    if (mExt) check(curReq, "msgData", msgData, mMsg);
    if (mLoop) check(curReq, "loopData", loopData, mMsg);
    expRd = regSel ? {mDest, 24'h0}
                   : (mLow | {mErr, 18'h0, (mExt || mLoop), 12'h0});
    check(curReq, "regRdData", 64'(regRdData), 64'(expRd));
  end

  task automatic wrHalf(logic sel, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    check("R1", "rd low", 64'(regRdData), 64'h0);
    check("R1", "msgValid", 64'(msgValid), 64'h0);
    rstN = 1'b1;
    idle(2);

    // R2: high write only sets destination
    curReq = "R2";
    wrHalf(1'b1, 32'h5A00_0000);
    check("R2", "msgValid", 64'(msgValid), 64'h0);
    regSel = 1'b1; #1;
    check("R2", "rd high", 64'(regRdData), 64'h5A00_0000);
    regSel = 1'b0; #1;
    check("R2", "rd low", 64'(regRdData), 64'h0);

    // R3/R4/R8/R9: unicast held off by msgReady, collision R10
    curReq = "R3";
    wrHalf(1'b0, lowWord(2'b00, 1'b1, 1'b1, 1'b1, 3'b000, 8'h31));
    check("R4", "msgData", msgData,
          {8'h5A, 36'h0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00, 1'b1, 3'b000, 8'h31});
    check("R8", "status", 64'(regRdData[12]), 64'h1);
    curReq = "R9";
    idle(3);
    check("R9", "msgValid held", 64'(msgValid), 64'h1);
    curReq = "R10";
    wrHalf(1'b0, lowWord(2'b01, 1'b0, 1'b0, 1'b0, 3'b010, 8'hEE));
    check("R10", "error bit", 64'(regRdData[31]), 64'h1);
    check("R10", "vector kept", 64'(regRdData[7:0]), 64'h31);
    check("R10", "msgData kept", 64'(msgData[7:0]), 64'h31);
    curReq = "R8";
    msgReady = 1'b1;
    idle(1);
    check("R8", "status cleared", 64'(regRdData[12]), 64'h0);
    idle(2);

    // R5: self
    curReq = "R5";
    wrHalf(1'b0, lowWord(2'b01, 1'b0, 1'b1, 1'b0, 3'b000, 8'h42));
    check("R5", "loopValid", 64'(loopValid), 64'h1);
    check("R5", "msgValid", 64'(msgValid), 64'h0);
    idle(1);
    check("R5", "loop pulse ends", 64'(loopValid), 64'h0);
    check("R5", "status", 64'(regRdData[12]), 64'h0);

    // R6: all including self, ready low for a while
    curReq = "R6";
    msgReady = 1'b0;
    wrHalf(1'b0, lowWord(2'b10, 1'b0, 1'b1, 1'b1, 3'b001, 8'h55));
    check("R6", "loopValid", 64'(loopValid), 64'h1);
    check("R6", "dest", 64'(msgData[63:56]), 64'hFF);
    idle(2);
    msgReady = 1'b1;
    idle(2);

    // R7: all excluding self forces physical
    curReq = "R7";
    wrHalf(1'b1, 32'h0300_0000);
    wrHalf(1'b0, lowWord(2'b11, 1'b0, 1'b1, 1'b1, 3'b110, 8'h9A));
    check("R7", "dest", 64'(msgData[63:56]), 64'hFF);
    check("R7", "dm", 64'(msgData[11]), 64'h0);
    check("R7", "loopValid", 64'(loopValid), 64'h0);
    idle(2);

    // R11: reserved type
    curReq = "R11";
    wrHalf(1'b0, lowWord(2'b00, 1'b0, 1'b1, 1'b0, 3'b011, 8'h10));
    check("R11", "msgValid", 64'(msgValid), 64'h0);
    check("R11", "type stored", 64'(regRdData[10:8]), 64'h3);
    check("R11", "status", 64'(regRdData[12]), 64'h0);

    // R12: NMI vector cleared, SMI passes
    curReq = "R12";
    wrHalf(1'b0, lowWord(2'b00, 1'b0, 1'b1, 1'b0, 3'b100, 8'h77));
    check("R12", "nmi vector", 64'(msgData[7:0]), 64'h00);
    check("R12", "nmi dest", 64'(msgData[63:56]), 64'h03);
    idle(2);
    wrHalf(1'b0, lowWord(2'b00, 1'b0, 1'b1, 1'b0, 3'b010, 8'h66));
    check("R12", "smi vector", 64'(msgData[7:0]), 64'h66);
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule